// File: doc/BRIEF.md
# Programmable Periodic Tick Generator

The block raises a periodic interrupt whose rate is chosen from a 128 Hz time base. A free-running divider turns strobes from the 32.768 kHz crystal domain into one base strobe per 256 crystal strobes. A down-counter then counts these base strobes. Each time it passes zero it issues a single-cycle pulse on a dedicated tick output and loads its count again.

Software programs the block through one byte-wide control register. Bit 7 enables the tick and bits 6:0 hold the reload count N. The tick rate is 128/(N+1) Hz, so a power-of-two rate f uses N = 128/f − 1. N = 127 gives 1 Hz and N = 0 gives 128 Hz.

Every write carries a field select. Software can replace the whole byte, only the count, or only the enable, and no read-modify-write sequence is needed. The register reads back at all times, so a saved value can be written back later to restore the tick exactly. Every accepted write reloads the counter and restarts the divider phase. The first tick after a write therefore comes exactly one full period later.

Top module: `tick_gen`

## Requirements
- R1: After reset the control readback is 8'h7F (enable clear, count 127, the 1 Hz setting) and the tick output is low.
- R2: A write with select 2'b00 stores all eight data bits, with bit 7 as the enable and bits 6:0 as the count, and they read back from the next cycle. Writing a saved readback value restores both the enable and the count.
- R3: A write with select 2'b01 replaces only the count (bits 6:0) and leaves the enable bit unchanged.
- R4: A write with select 2'b10 replaces only the enable with data bit 7 and leaves the count unchanged.
- R5: A write with select 2'b11 has no effect on the register and does not reload the counter.
- R6: The divider produces one base strobe per DIV crystal strobes. Cycles without a crystal strobe do not advance it, so halving the crystal strobe rate doubles the tick period.
- R7: While enabled with count N, the tick output pulses high for exactly one cycle every (N+1)·DIV crystal strobes. This covers both extremes, N = 0 (128 Hz) and N = 127 (1 Hz).
- R8: An accepted write (select 2'b00, 2'b01 or 2'b10) reloads the counter and restarts the divider. With the crystal strobing every cycle and the block enabled, the next tick appears (N+1)·DIV cycles after the write edge, whatever phase the old count had reached.
- R9: While the enable bit is clear no tick is produced, including after the count is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| xtal_stb_i | input | 1 | One-cycle strobe per crystal clock period, already in the clk domain |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write field select: 00 whole byte, 01 count only, 10 enable only, 11 none |
| wr_data_i | input | 8 | Write data: bit 7 enable, bits 6:0 count |
| ctrl_o | output | 8 | Control register readback |
| tick_irq_o | output | 1 | Single-cycle periodic tick interrupt |

## Verification
The counter and divider state is visible only through when the tick fires, so a wrong count, a missed reload or a stray divider phase shows up as a pulse at the wrong cycle. A stray phase can shift the pulse by up to one base period of DIV cycles. A wrong count shifts the first pulse by a multiple of DIV and then repeats the error every period. The bench predicts the exact cycle of every pulse from each write, so it catches a misplaced, missing or extra pulse at the first tick where it occurs. The bench also flags a register field that is corrupted by a partial write on the readback in the cycle right after the write.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int TICK_CNT_W = 7;
  localparam int TICK_REG_W = TICK_CNT_W + 1;

  typedef enum logic [1:0] {
    WR_FULL   = 2'b00,
    WR_COUNT  = 2'b01,
    WR_ENABLE = 2'b10,
    WR_NONE   = 2'b11
  } wr_sel_e;

  typedef struct packed {
    logic                  en;
    logic [TICK_CNT_W-1:0] cnt;
  } tick_ctrl_t;

  localparam tick_ctrl_t TICK_CTRL_RST = '{en: 1'b0, cnt: {TICK_CNT_W{1'b1}}};

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic xtal_stb_i,
  output logic base_stb_o
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             div_ce;

  always_comb begin
    div_ce = restart_i | xtal_stb_i;
    if (restart_i) begin
      div_d = '0;
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  assign base_stb_o = xtal_stb_i & ~restart_i & (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_ce) begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  wr_sel_e               wr_sel_i,
  input  logic [TICK_REG_W-1:0] wr_data_i,
  output tick_ctrl_t            ctrl_q_o,
  output tick_ctrl_t            ctrl_d_o,
  output logic                  reload_o
);

  tick_ctrl_t ctrl_q, ctrl_d;
  logic       ctrl_ce;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_ce = 1'b0;
    if (wr_i) begin
      unique case (wr_sel_i)
        WR_FULL: begin
          ctrl_d  = tick_ctrl_t'(wr_data_i);
          ctrl_ce = 1'b1;
        end
        WR_COUNT: begin
          ctrl_d.cnt = wr_data_i[TICK_CNT_W-1:0];
          ctrl_ce    = 1'b1;
        end
        WR_ENABLE: begin
          ctrl_d.en = wr_data_i[TICK_REG_W-1];
          ctrl_ce   = 1'b1;
        end
        default: begin
          ctrl_ce = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= TICK_CTRL_RST;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_q_o = ctrl_q;
  assign ctrl_d_o = ctrl_d;
  assign reload_o = ctrl_ce;

endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cur_val_i,
  input  logic             base_stb_i,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             irq_q, irq_d;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    irq_d  = 1'b0;
    if (reload_i) begin
      cnt_d  = load_val_i;
      cnt_ce = 1'b1;
    end else if (!en_i) begin
      cnt_d  = cur_val_i;
      cnt_ce = 1'b1;
    end else if (base_stb_i) begin
      cnt_ce = 1'b1;
      if (cnt_q == '0) begin
        cnt_d = cur_val_i;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import tick_pkg::*;
#(
  parameter int DIV = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xtal_stb_i,
  input  logic                  wr_i,
  input  logic [1:0]            wr_sel_i,
  input  logic [TICK_REG_W-1:0] wr_data_i,
  output logic [TICK_REG_W-1:0] ctrl_o,
  output logic                  tick_irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  tick_ctrl_t ctrl_q, ctrl_d;
  logic       reload;
  logic       base_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  tick_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_i      (wr_i),
    .wr_sel_i  (wr_sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .ctrl_q_o  (ctrl_q),
    .ctrl_d_o  (ctrl_d),
    .reload_o  (reload)
  );

  tick_prescaler #(.DIV(DIV)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .restart_i  (reload),
    .xtal_stb_i (xtal_stb_i),
    .base_stb_o (base_stb)
  );

  tick_downcounter #(.CNT_W(TICK_CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en_i       (ctrl_q.en),
    .reload_i   (reload),
    .load_val_i (ctrl_d.cnt),
    .cur_val_i  (ctrl_q.cnt),
    .base_stb_i (base_stb),
    .irq_o      (tick_irq_o)
  );

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xtal_stb_i,
  input logic       wr_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] ctrl_o,
  input logic       tick_irq_o,
  input logic       base_stb
);

  // R3: a count-only write leaves the enable bit alone
  a_r3_keep_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_sel_i == 2'b01) |=> (ctrl_o[7] == $past(ctrl_o[7])));

  // R4: an enable-only write leaves the count alone
  a_r4_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_sel_i == 2'b10) |=> (ctrl_o[6:0] == $past(ctrl_o[6:0])));

  // R5: the reserved select changes nothing
  a_r5_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_sel_i == 2'b11) |=> $stable(ctrl_o));

  // R6: a base strobe only ever accompanies a crystal strobe
  a_r6_base_needs_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    base_stb |-> xtal_stb_i);

  // R7: the tick is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq_o |=> !tick_irq_o);

  // R8: an accepted write restarts the period, so no tick follows it directly
  a_r8_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_sel_i != 2'b11) |=> !tick_irq_o);

  // R9: with the enable clear no tick follows
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[7] |=> !tick_irq_o);

endmodule

bind tick_gen tick_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xtal_stb_i (xtal_stb_i),
  .wr_i       (wr_i),
  .wr_sel_i   (wr_sel_i),
  .ctrl_o     (ctrl_o),
  .tick_irq_o (tick_irq_o),
  .base_stb   (base_stb)
);

// File: tb/tick_gen_tb.sv
module tick_gen_tb;

  localparam int DIV = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_stb = 1'b1;
  logic       half_rate = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl;
  logic       irq;

  int unsigned cyc = 0;
  int          compared = 0;
  int          mismatched = 0;
  int unsigned exp_q[$];
  string       cur_tag = "R1";
  logic        done = 1'b0;

  tick_gen #(.DIV(DIV)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .xtal_stb_i (xtal_stb),
    .wr_i       (wr),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .ctrl_o     (ctrl),
    .tick_irq_o (irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) xtal_stb <= half_rate ? cyc[0] : 1'b1;

  // monitor: every tick must match the oldest expected cycle
  always @(negedge clk) begin
    if (rst_n && irq) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL %s: tick at cycle %0d, expected no tick", cur_tag, cyc);
      end else begin
        int unsigned e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          mismatched++;
          $display("FAIL %s: tick at cycle %0d, expected cycle %0d", cur_tag, cyc, e);
        end
      end
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: readback %02h, expected %02h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] data,
                           output int unsigned w);
    @(negedge clk);
    wr = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr = 1'b0; wr_sel = 2'b00; wr_data = 8'h00;
    w = cyc;
  endtask

  task automatic push_train(input int unsigned first, input int unsigned period, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(first + i * period);
  endtask

  task automatic drain(input string tag, input int unsigned until_cyc);
    while (cyc < until_cyc) @(negedge clk);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL %s: %0d ticks missing, expected 0 missing", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    int unsigned w;
    int unsigned p;
    int unsigned first;
    logic [7:0]  saved;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check8("R1", ctrl, 8'h7F);
    compared++;
    if (irq !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: tick %b, expected 0", irq);
    end

    // R2 / R7: whole-byte write, enable with N=3
    cur_tag = "R7";
    write_reg(2'b00, 8'h83, w);
    check8("R2", ctrl, 8'h83);
    p = 4 * DIV;
    push_train(w + p, p, 3);
    drain("R7", w + 3 * p + 4);

    // R8: rewrite mid-period restarts the full period
    cur_tag = "R8";
    write_reg(2'b00, 8'h83, w);
    repeat (600) @(negedge clk);
    write_reg(2'b00, 8'h83, w);
    push_train(w + 4 * DIV, 4 * DIV, 2);
    drain("R8", w + 8 * DIV + 4);

    // R3 / R7: count-only write to N=0 keeps the enable, 128 Hz rate
    cur_tag = "R7";
    write_reg(2'b01, 8'h00, w);
    check8("R3", ctrl, 8'h80);
    push_train(w + DIV, DIV, 4);
    drain("R7", w + 4 * DIV + 4);

    // R4 / R9: enable-only write clears the enable, count kept, no ticks
    cur_tag = "R9";
    write_reg(2'b10, 8'h7F, w);
    check8("R4", ctrl, 8'h00);
    write_reg(2'b01, 8'h05, w);
    check8("R3", ctrl, 8'h05);
    drain("R9", w + 1500);

    // R5: reserved select leaves the register alone
    cur_tag = "R5";
    write_reg(2'b11, 8'hFF, w);
    check8("R5", ctrl, 8'h05);
    drain("R5", w + 2 * DIV);

    // R4: enable-only write sets the enable, count 5 kept
    cur_tag = "R4";
    write_reg(2'b10, 8'h80, w);
    check8("R4", ctrl, 8'h85);
    p = 6 * DIV;
    push_train(w + p, p, 2);
    drain("R4", w + 2 * p + 4);

    // R2: save, disable, restore
    cur_tag = "R2";
    saved = ctrl;
    write_reg(2'b00, 8'h00, w);
    check8("R2", ctrl, 8'h00);
    repeat (700) @(negedge clk);
    write_reg(2'b00, saved, w);
    check8("R2", ctrl, 8'h85);
    push_train(w + p, p, 1);
    drain("R2", w + p + 4);

    // R6: crystal strobe on alternate cycles doubles the period (N=1)
    cur_tag = "R6";
    half_rate = 1'b1;
    @(negedge clk);
    write_reg(2'b00, 8'h81, w);
    p = 2 * 2 * DIV;
    first = w + p - (w % 2);
    push_train(first, p, 2);
    drain("R6", first + p + 4);
    half_rate = 1'b0;
    write_reg(2'b00, 8'h00, w);
    @(negedge clk);

    // R7: N=127, the 1 Hz setting
    cur_tag = "R7";
    write_reg(2'b00, 8'hFF, w);
    check8("R7", ctrl, 8'hFF);
    push_train(w + 128 * DIV, 128 * DIV, 1);
    drain("R7", w + 128 * DIV + 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run reached cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule